// File: doc/BRIEF.md
# I2C Register-Map Target with Word-Length Auto-Increment

This block is the two-wire serial target through which an outside controller reaches a chip's internal registers and memories. The controller addresses the target with a 7-bit device address. For a write it then sends a 16-bit subaddress and data. For a read it sets the subaddress in the same way, issues a repeated START and readdresses the target with the direction bit set. The target only ever pulls SDA low: it has an open-drain enable and never drives the line high. SCL is an input only, and the target never stretches the clock.

Each register occupies one subaddress and is between one and five bytes wide. The width depends on which range of the map the subaddress falls in. Bytes travel most significant first. The subaddress steps by one only when a whole word has been moved, so a burst walks through registers of different widths without any help from the controller. On the internal side there is a plain parallel port. A write strobe carries a finished word with its address. A read strobe fetches a word just before its first byte leaves. Subaddresses outside the map, and bursts that run past the top of the map, are handled differently for reads and for writes.

Top module: `i2c_burst_target`

## Requirements
- R1: The target answers only when the 7 received address bits equal DEV_BASE with its low ASEL_W bits replaced by `addr_sel`. On any other address it does not acknowledge and waits for the next START.
- R2: Every accepted byte is acknowledged by asserting `sda_oe` through the ninth SCL pulse. `sda_oe` is only ever raised while SCL is low.
- R3: The two subaddress bytes arrive high byte first. A subaddress above TOP is not acknowledged on its low byte, and the target returns to idle.
- R4: The word length is 1 byte below LEN2_FROM, 2 from LEN2_FROM, 3 from LEN3_FROM, 4 from LEN4_FROM, and 5 from LEN5_FROM up to TOP (defaults 16, 32, 48, 56 and 63).
- R5: A write word is taken most significant byte first. It is presented right-justified on `reg_wdata`, with a one-cycle `reg_wr`, only after its last byte has been acknowledged.
- R6: In a burst the subaddress rises by exactly one for each completed word, whatever the word length.
- R7: A single-word write closed by STOP does not move the subaddress. A following read with no new subaddress returns that same register.
- R8: In a write burst, a byte that would land past TOP is not acknowledged and is not stored. No `reg_wr` follows, and the target goes idle.
- R9: After a repeated START with the direction bit at 1, the target fetches each word with one `reg_rd` pulse and shifts it out MSB first. It continues while the controller acknowledges and stops at a controller NACK.
- R10: A read burst that passes TOP keeps returning the contents of register TOP.
- R11: A START or STOP at any point abandons the current transfer. A partly received word is never written.
- R12: `reg_wr` and `reg_rd` are single-cycle pulses and are never high together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| addr_sel | input | ASEL_W | Low bits of the device address |
| scl_i | input | 1 | Serial clock line as seen on the pin |
| sda_i | input | 1 | Serial data line as seen on the pin |
| sda_oe | output | 1 | 1 pulls SDA low; 0 releases it |
| reg_addr | output | 16 | Register address for both strobes |
| reg_wr | output | 1 | Write strobe, one cycle |
| reg_wdata | output | 40 | Write word, right-justified |
| reg_rd | output | 1 | Read strobe, one cycle |
| reg_rdata | input | 40 | Read word, right-justified, valid while `reg_rd` is high |

## Verification
Bursts start in the 2-byte range and cross into the 3-byte range, so a wrong length decode or a step taken per byte shows up in the stored words. Lone 1-byte and 4-byte writes check the end ranges on their own. A second, independent direct read checks that a single write left the address alone. Read bursts start below and at TOP, which separates correct saturation from wrap-around or an early stop. Invalid subaddresses, overruns, a wrong device address and a transfer cut short by STOP show whether each failure path refuses the byte and leaves the register port untouched.

// File: rtl/i2c_burst_pkg.sv
package i2c_burst_pkg;
  localparam int unsigned SUB_W   = 16;
  localparam int unsigned MAXLEN  = 5;
  localparam int unsigned WORD_W  = 8 * MAXLEN;
  localparam int unsigned LEN_W   = 3;

  typedef enum logic [2:0] {
    S_IDLE, S_RX, S_ACK, S_LOAD, S_TX, S_MACK
  } st_t;

  typedef enum logic [1:0] {
    K_DEV, K_SUBH, K_SUBL, K_DATA
  } kind_t;
endpackage

// File: rtl/i2c_line_sync.sv
module i2c_line_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic line_i,
  output logic lvl,
  output logic rise,
  output logic fall
);
  logic [STAGES:0] sh_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sh_q <= '1;
    else        sh_q <= {sh_q[STAGES-1:0], line_i};
  end

  assign lvl  = sh_q[STAGES-1];
  assign rise = sh_q[STAGES-1] & ~sh_q[STAGES];
  assign fall = ~sh_q[STAGES-1] & sh_q[STAGES];
endmodule

// File: rtl/i2c_wlen_dec.sv
module i2c_wlen_dec import i2c_burst_pkg::*; #(
  parameter logic [SUB_W-1:0] LEN2_FROM = 16'd16,
  parameter logic [SUB_W-1:0] LEN3_FROM = 16'd32,
  parameter logic [SUB_W-1:0] LEN4_FROM = 16'd48,
  parameter logic [SUB_W-1:0] LEN5_FROM = 16'd56
) (
  input  logic [SUB_W-1:0] sub,
  output logic [LEN_W-1:0] len
);
  always_comb begin
    if      (sub < LEN2_FROM) len = 3'd1;
    else if (sub < LEN3_FROM) len = 3'd2;
    else if (sub < LEN4_FROM) len = 3'd3;
    else if (sub < LEN5_FROM) len = 3'd4;
    else                      len = 3'd5;
  end
endmodule

// File: rtl/i2c_burst_target.sv
module i2c_burst_target import i2c_burst_pkg::*; #(
  parameter logic [6:0]       DEV_BASE    = 7'h34,
  parameter int unsigned      ASEL_W      = 2,
  parameter int unsigned      SYNC_STAGES = 2,
  parameter logic [SUB_W-1:0] LEN2_FROM   = 16'd16,
  parameter logic [SUB_W-1:0] LEN3_FROM   = 16'd32,
  parameter logic [SUB_W-1:0] LEN4_FROM   = 16'd48,
  parameter logic [SUB_W-1:0] LEN5_FROM   = 16'd56,
  parameter logic [SUB_W-1:0] TOP         = 16'd63
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ASEL_W-1:0] addr_sel,
  input  logic              scl_i,
  input  logic              sda_i,
  output logic              sda_oe,
  output logic [SUB_W-1:0]  reg_addr,
  output logic              reg_wr,
  output logic [WORD_W-1:0] reg_wdata,
  output logic              reg_rd,
  input  logic [WORD_W-1:0] reg_rdata
);
  localparam logic [SUB_W:0] TOP_X = {1'b0, TOP};

  // reset: asserted asynchronously, released on the clock
  logic [1:0] rst_sh;
  logic       rst_q_n;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sh <= 2'b00;
    else        rst_sh <= {rst_sh[0], 1'b1};
  end
  assign rst_q_n = rst_sh[1];

  logic scl_lvl, scl_rise, scl_fall, sda_lvl, sda_rise, sda_fall;
  i2c_line_sync #(.STAGES(SYNC_STAGES)) u_scl (.clk(clk), .rst_n(rst_q_n), .line_i(scl_i),
    .lvl(scl_lvl), .rise(scl_rise), .fall(scl_fall));
  i2c_line_sync #(.STAGES(SYNC_STAGES)) u_sda (.clk(clk), .rst_n(rst_q_n), .line_i(sda_i),
    .lvl(sda_lvl), .rise(sda_rise), .fall(sda_fall));

  st_t               st, st_n;
  kind_t             kind, kind_n;
  logic [3:0]        bitcnt, bitcnt_n;
  logic [7:0]        shreg, shreg_n, sub_hi, sub_hi_n;
  logic [SUB_W-1:0]  addr, addr_n;
  logic [LEN_W-1:0]  bytecnt, bytecnt_n, wlen, wlen_n;
  logic [WORD_W-1:0] wbuf, wbuf_n, rword, rword_n;
  logic              rw, rw_n, pend, pend_n, commit, commit_n, nack, nack_n;
  logic              oe, oe_n, wr_q, wr_n, rd_q, rd_n;

  logic [6:0]        dev_id;
  logic              start_c, stop_c, last_r, adv_r, go_read;
  logic [SUB_W:0]    ea_w;
  logic [SUB_W-1:0]  ea_r;
  logic [LEN_W-1:0]  len_w, len_r, ln_w;
  logic [7:0]        pick;

  assign dev_id  = {DEV_BASE[6:ASEL_W], addr_sel};
  assign start_c = scl_lvl & sda_fall;
  assign stop_c  = scl_lvl & sda_rise;
  assign last_r  = (bytecnt + 3'd1) == wlen;
  assign adv_r   = (st == S_MACK) ? last_r : pend;
  assign ea_r    = (adv_r && addr < TOP) ? addr + 16'd1 : addr;
  assign ea_w    = pend ? {1'b0, addr} + 17'd1 : {1'b0, addr};
  assign ln_w    = (bytecnt == 3'd0) ? len_w : wlen;

  i2c_wlen_dec #(.LEN2_FROM(LEN2_FROM), .LEN3_FROM(LEN3_FROM), .LEN4_FROM(LEN4_FROM),
    .LEN5_FROM(LEN5_FROM)) u_dec_w (.sub(ea_w[SUB_W-1:0]), .len(len_w));
  i2c_wlen_dec #(.LEN2_FROM(LEN2_FROM), .LEN3_FROM(LEN3_FROM), .LEN4_FROM(LEN4_FROM),
    .LEN5_FROM(LEN5_FROM)) u_dec_r (.sub(ea_r), .len(len_r));

  // byte idx of a len-byte word, counted from the most significant end
  function automatic logic [7:0] word_byte(input logic [WORD_W-1:0] w,
                                           input logic [LEN_W-1:0] len,
                                           input logic [LEN_W-1:0] idx);
    logic [LEN_W-1:0] k;
    k = len - 3'd1 - idx;
    return w[{k, 3'b000} +: 8];
  endfunction

  always_comb begin
    st_n = st;  kind_n = kind;  bitcnt_n = bitcnt;  shreg_n = shreg;
    sub_hi_n = sub_hi;  addr_n = addr;  bytecnt_n = bytecnt;  wlen_n = wlen;
    wbuf_n = wbuf;  rword_n = rword;  rw_n = rw;  pend_n = pend;
    commit_n = commit;  nack_n = nack;  oe_n = oe;
    wr_n = 1'b0;  rd_n = 1'b0;  go_read = 1'b0;  pick = 8'h00;
    if (stop_c) begin
      st_n = S_IDLE;  oe_n = 1'b0;  pend_n = 1'b0;  bytecnt_n = '0;  commit_n = 1'b0;
    end else if (start_c) begin
      st_n = S_RX;  kind_n = K_DEV;  bitcnt_n = '0;  oe_n = 1'b0;
      bytecnt_n = '0;  commit_n = 1'b0;
    end else begin
      unique case (st)
        S_IDLE: ;
        S_RX: begin
          if (scl_rise && bitcnt < 4'd8) begin
            shreg_n  = {shreg[6:0], sda_lvl};
            bitcnt_n = bitcnt + 4'd1;
          end else if (scl_fall && bitcnt == 4'd8) begin
            bitcnt_n = '0;
            st_n     = S_IDLE;
            unique case (kind)
              K_DEV: if (shreg[7:1] == dev_id) begin
                rw_n = shreg[0];  st_n = S_ACK;  oe_n = 1'b1;
              end
              K_SUBH: begin
                sub_hi_n = shreg;  kind_n = K_SUBL;  st_n = S_ACK;  oe_n = 1'b1;
              end
              K_SUBL: if ({sub_hi, shreg} <= TOP) begin
                addr_n = {sub_hi, shreg};  pend_n = 1'b0;  bytecnt_n = '0;
                kind_n = K_DATA;  st_n = S_ACK;  oe_n = 1'b1;
              end
              K_DATA: if (ea_w <= TOP_X) begin
                addr_n = ea_w[SUB_W-1:0];  pend_n = 1'b0;  wlen_n = ln_w;
                wbuf_n = (bytecnt == 3'd0) ? {{(WORD_W-8){1'b0}}, shreg}
                                           : {wbuf[WORD_W-9:0], shreg};
                if (bytecnt + 3'd1 == ln_w) begin
                  commit_n = 1'b1;  bytecnt_n = '0;  pend_n = 1'b1;
                end else begin
                  bytecnt_n = bytecnt + 3'd1;
                end
                st_n = S_ACK;  oe_n = 1'b1;
              end
            endcase
          end
        end
        S_ACK: if (scl_fall) begin
          oe_n = 1'b0;
          if (commit) begin
            wr_n = 1'b1;  commit_n = 1'b0;
          end
          if (kind == K_DEV && rw) go_read = 1'b1;
          else begin
            st_n = S_RX;
            if (kind == K_DEV) kind_n = K_SUBH;
          end
        end
        S_LOAD: begin
          rword_n  = reg_rdata;
          pick     = word_byte(reg_rdata, wlen, 3'd0);
          shreg_n  = pick;  oe_n = ~pick[7];  bitcnt_n = '0;  st_n = S_TX;
        end
        S_TX: if (scl_fall) begin
          if (bitcnt == 4'd7) begin
            oe_n = 1'b0;  st_n = S_MACK;  bitcnt_n = '0;
          end else begin
            shreg_n  = {shreg[6:0], 1'b0};
            oe_n     = ~shreg[6];
            bitcnt_n = bitcnt + 4'd1;
          end
        end
        S_MACK: begin
          if (scl_rise) nack_n = sda_lvl;
          if (scl_fall) begin
            bytecnt_n = last_r ? 3'd0 : bytecnt + 3'd1;
            pend_n    = last_r | pend;
            if (nack)        st_n = S_IDLE;
            else if (last_r) go_read = 1'b1;
            else begin
              pick    = word_byte(rword, wlen, bytecnt + 3'd1);
              shreg_n = pick;  oe_n = ~pick[7];  bitcnt_n = '0;  st_n = S_TX;
            end
          end
        end
        default: st_n = S_IDLE;
      endcase
      if (go_read) begin
        addr_n = ea_r;  pend_n = 1'b0;  wlen_n = len_r;  bytecnt_n = '0;
        rd_n = 1'b1;  st_n = S_LOAD;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_q_n) begin
    if (!rst_q_n) begin
      st <= S_IDLE;  kind <= K_DEV;  bitcnt <= '0;  shreg <= '0;  sub_hi <= '0;
      addr <= '0;  bytecnt <= '0;  wlen <= 3'd1;  wbuf <= '0;  rword <= '0;
      rw <= 1'b0;  pend <= 1'b0;  commit <= 1'b0;  nack <= 1'b0;
      oe <= 1'b0;  wr_q <= 1'b0;  rd_q <= 1'b0;
    end else begin
      st <= st_n;  kind <= kind_n;  bitcnt <= bitcnt_n;  shreg <= shreg_n;
      sub_hi <= sub_hi_n;  addr <= addr_n;  bytecnt <= bytecnt_n;  wlen <= wlen_n;
      wbuf <= wbuf_n;  rword <= rword_n;  rw <= rw_n;  pend <= pend_n;
      commit <= commit_n;  nack <= nack_n;  oe <= oe_n;  wr_q <= wr_n;  rd_q <= rd_n;
    end
  end

  assign sda_oe    = oe;
  assign reg_addr  = addr;
  assign reg_wr    = wr_q;
  assign reg_wdata = wbuf;
  assign reg_rd    = rd_q;
endmodule

// File: rtl/i2c_burst_chk.sv
module i2c_burst_chk import i2c_burst_pkg::*; #(
  parameter logic [SUB_W-1:0] TOP = 16'd63
) (
  input logic             clk,
  input logic             rst_n,
  input logic             scl_q,
  input logic             sda_oe,
  input logic             reg_wr,
  input logic             reg_rd,
  input logic [SUB_W-1:0] reg_addr
);
  assert_oe_rise_scl_low_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sda_oe) |-> !scl_q);

  assert_strobe_excl_R12: assert property (@(posedge clk) disable iff (!rst_n)
    !(reg_wr && reg_rd));

  assert_wr_single_R12: assert property (@(posedge clk) disable iff (!rst_n)
    reg_wr |=> !reg_wr);

  assert_rd_single_R12: assert property (@(posedge clk) disable iff (!rst_n)
    reg_rd |=> !reg_rd);

  // covers R8 and R10: the register port never sees an address past the map
  assert_addr_in_map_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wr || reg_rd) |-> reg_addr <= TOP);
endmodule

bind i2c_burst_target i2c_burst_chk #(.TOP(TOP)) u_chk (
  .clk(clk), .rst_n(rst_n), .scl_q(scl_lvl), .sda_oe(sda_oe),
  .reg_wr(reg_wr), .reg_rd(reg_rd), .reg_addr(reg_addr));

// File: tb/sim_i2c_burst_target.sv
module sim_i2c_burst_target;
  logic        clk = 1'b0;
  logic        rst_n;
  logic [1:0]  addr_sel;
  logic        scl_m, sda_m;
  logic        sda_bus, sda_oe, reg_wr, reg_rd;
  logic [15:0] reg_addr;
  logic [39:0] reg_wdata, reg_rdata;
  logic [39:0] mem [0:63];
  int          n_chk = 0, n_fail = 0, wr_cnt = 0, rd_cnt = 0;
  localparam logic [6:0] DEV = 7'h35;  // base 0x34 with addr_sel = 1

  always #10 clk = ~clk;
  assign sda_bus   = sda_m & ~sda_oe;
  assign reg_rdata = (reg_addr < 16'd64) ? mem[reg_addr[5:0]] : 40'h0;

  always @(posedge clk) begin
    if (reg_wr) begin
      if (reg_addr < 16'd64) mem[reg_addr[5:0]] <= reg_wdata;
      wr_cnt <= wr_cnt + 1;
    end
    if (reg_rd) rd_cnt <= rd_cnt + 1;
  end

  i2c_burst_target u0 (.clk(clk), .rst_n(rst_n), .addr_sel(addr_sel), .scl_i(scl_m),
    .sda_i(sda_bus), .sda_oe(sda_oe), .reg_addr(reg_addr), .reg_wr(reg_wr),
    .reg_wdata(reg_wdata), .reg_rd(reg_rd), .reg_rdata(reg_rdata));

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic check(input string req, input logic [39:0] act, input logic [39:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic report;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  endtask

  task automatic m_start;
    sda_m = 1'b1; tick(5); scl_m = 1'b1; tick(5); sda_m = 1'b0; tick(5); scl_m = 1'b0; tick(5);
  endtask

  task automatic m_stop;
    sda_m = 1'b0; tick(5); scl_m = 1'b1; tick(5); sda_m = 1'b1; tick(10);
  endtask

  task automatic m_wr(input logic [7:0] b, output logic ack);
    for (int i = 7; i >= 0; i--) begin
      sda_m = b[i]; tick(5); scl_m = 1'b1; tick(10); scl_m = 1'b0; tick(5);
    end
    sda_m = 1'b1; tick(5); scl_m = 1'b1; tick(5); ack = sda_bus; tick(5); scl_m = 1'b0; tick(5);
  endtask

  task automatic m_rd(input logic nk, output logic [7:0] b);
    sda_m = 1'b1;
    for (int i = 7; i >= 0; i--) begin
      tick(5); scl_m = 1'b1; tick(5); b[i] = sda_bus; tick(5); scl_m = 1'b0;
    end
    tick(5); sda_m = nk; tick(5); scl_m = 1'b1; tick(10); scl_m = 1'b0; tick(5); sda_m = 1'b1;
  endtask

  // START, device write, two subaddress bytes; returns the OR of the three ack bits
  task automatic set_ptr(input logic [15:0] sub, output logic bad);
    logic a0, a1, a2;
    m_start; m_wr({DEV, 1'b0}, a0); m_wr(sub[15:8], a1); m_wr(sub[7:0], a2);
    bad = a0 | a1 | a2;
  endtask

  task automatic t_reset;
    rst_n = 1'b0; scl_m = 1'b1; sda_m = 1'b1; addr_sel = 2'b01;
    for (int i = 0; i < 64; i++) mem[i] = 40'h0;
    tick(4);
    check("R12 reset wr", {39'h0, reg_wr}, 40'h0);
    check("R12 reset rd", {39'h0, reg_rd}, 40'h0);
    rst_n = 1'b1; tick(6);
    check("R2 idle oe", {39'h0, sda_oe}, 40'h0);
  endtask

  task automatic t_wrong_dev;
    logic a;
    m_start; m_wr({7'h34, 1'b0}, a); m_stop;
    check("R1 foreign address nacked", {39'h0, a}, 40'h1);
    m_start; m_wr({DEV, 1'b0}, a); m_stop;
    check("R1 own address acked", {39'h0, a}, 40'h0);
  endtask

  task automatic t_single_write_readback;
    logic bad, a; logic [7:0] b; int w0;
    w0 = wr_cnt;
    set_ptr(16'd5, bad); m_wr(8'hAB, a); m_stop;
    check("R2 acks single write", {39'h0, bad | a}, 40'h0);
    check("R5 1-byte word stored", mem[5], 40'hAB);
    check("R5 one strobe", 40'(wr_cnt - w0), 40'd1);
    m_start; m_wr({DEV, 1'b1}, a); m_rd(1'b1, b); m_stop;
    check("R7 address kept after single write", {32'h0, b}, 40'hAB);
  endtask

  task automatic t_burst_write;
    logic bad, a, acc; int w0;
    w0 = wr_cnt; acc = 1'b0;
    set_ptr(16'd30, bad);
    for (int i = 1; i <= 7; i++) begin m_wr(8'((i << 4) | i), a); acc |= a; end
    m_stop;
    check("R2 burst acks", {39'h0, bad | acc}, 40'h0);
    check("R4 R6 2-byte word at 30", mem[30], 40'h1122);
    check("R6 2-byte word at 31", mem[31], 40'h3344);
    check("R4 R6 3-byte word at 32", mem[32], 40'h556677);
    check("R6 three strobes", 40'(wr_cnt - w0), 40'd3);
  endtask

  task automatic t_four_byte;
    logic bad, a0, a1, a2, a3;
    set_ptr(16'd50, bad);
    m_wr(8'hDE, a0); m_wr(8'hAD, a1); m_wr(8'hBE, a2); m_wr(8'hEF, a3); m_stop;
    check("R4 R5 4-byte word at 50", mem[50], 40'hDEADBEEF);
  endtask

  task automatic t_bad_sub;
    logic a0, a1, a2; int w0;
    w0 = wr_cnt;
    m_start; m_wr({DEV, 1'b0}, a0); m_wr(8'h01, a1); m_wr(8'h05, a2);
    check("R3 high byte first, 0x0105 refused", {39'h0, a2}, 40'h1);
    m_wr(8'h77, a0); m_stop;
    check("R3 idle after refusal", {39'h0, a0}, 40'h1);
    check("R3 no strobe", 40'(wr_cnt - w0), 40'd0);
    m_start; m_wr({DEV, 1'b0}, a0); m_wr(8'h00, a1); m_wr(8'h3F, a2); m_stop;
    check("R3 0x003F accepted", {39'h0, a2}, 40'h0);
  endtask

  task automatic t_write_overrun;
    logic bad, a, acc; int w0;
    w0 = wr_cnt; acc = 1'b0;
    set_ptr(16'd63, bad);
    for (int i = 1; i <= 5; i++) begin m_wr(8'(i), a); acc |= a; end
    m_wr(8'hEE, a); m_stop;
    check("R4 5-byte word at top", mem[63], 40'h0102030405);
    check("R8 overrun byte nacked", {39'h0, a}, 40'h1);
    check("R8 only one strobe", 40'(wr_cnt - w0), 40'd1);
    check("R8 top acks", {39'h0, bad | acc}, 40'h0);
  endtask

  task automatic t_burst_read;
    logic bad, a; logic [7:0] b0, b1, b2, b3; int r0;
    mem[14] = 40'h5A; mem[15] = 40'hC3; mem[16] = 40'h1234;
    r0 = rd_cnt;
    set_ptr(16'd14, bad); m_start; m_wr({DEV, 1'b1}, a);
    m_rd(1'b0, b0); m_rd(1'b0, b1); m_rd(1'b0, b2); m_rd(1'b1, b3); m_stop;
    check("R9 read acks", {39'h0, bad | a}, 40'h0);
    check("R9 byte 14", {32'h0, b0}, 40'h5A);
    check("R6 R9 byte 15", {32'h0, b1}, 40'hC3);
    check("R9 MSB first at 16", {24'h0, b2, b3}, 40'h1234);
    check("R12 one fetch per word", 40'(rd_cnt - r0), 40'd3);
  endtask

  task automatic t_read_overrun;
    logic bad, a; logic [7:0] b; logic [39:0] w1, w2;
    set_ptr(16'd63, bad); m_start; m_wr({DEV, 1'b1}, a);
    for (int i = 0; i < 5; i++) begin m_rd(1'b0, b); w1 = {w1[31:0], b}; end
    for (int i = 0; i < 5; i++) begin m_rd(i == 4, b); w2 = {w2[31:0], b}; end
    m_stop;
    check("R10 first top word", w1, 40'h0102030405);
    check("R10 top repeated past end", w2, 40'h0102030405);
  endtask

  task automatic t_abort;
    logic bad, a; int w0;
    w0 = wr_cnt;
    set_ptr(16'd40, bad); m_wr(8'h99, a); m_wr(8'h98, a); m_stop;
    check("R11 partial word dropped", mem[40], 40'h0);
    check("R11 no strobe after STOP", 40'(wr_cnt - w0), 40'd0);
    m_start; m_wr({DEV, 1'b0}, a);
    set_ptr(16'd41, bad);
    m_wr(8'hAA, a); m_wr(8'hBB, a); m_wr(8'hCC, a); m_stop;
    check("R11 recovery after early START", mem[41], 40'hAABBCC);
  endtask

  initial begin
    t_reset;
    t_wrong_dev;
    t_single_write_readback;
    t_burst_write;
    t_four_byte;
    t_bad_sub;
    t_write_overrun;
    t_burst_read;
    t_read_overrun;
    t_abort;
    report;
  end

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog: run did not end");
    report;
  end
endmodule